// File: doc/BRIEF.md
# Requester ID Range Mapper

This block turns the 16-bit requester identity of an incoming PCIe request into two values that an address-translation unit needs: which translation unit (a small index) serves the request, and which sideband identifier that unit should use. The identity is first ANDed with a programmable mask. The masked value is then compared in parallel against a table of range entries.

Each entry holds four values: a range start, a range length, a target unit index, and a relocation base for the output identifier. A masked identity falls in an entry when it is at or above the start and strictly below start plus length. The output identifier is the distance from the range start, added to the relocation base.

The table and the mask are loaded through a synchronous write port, one entry per cycle. Lookups are single-cycle and registered. Typical uses are:
- an identity map over the whole space;
- a per-device map that ignores function numbers;
- a split that sends the lower and upper halves of the bus space to different units, or swaps those halves.

Top module: `rmap_unit`

## Requirements
- R1: The lookup uses the requester identity ANDed with the mask register. The mask is 0xFFFF after reset. With mask 0xFFF8, the function bits [2:0] are ignored, so every function of one device (bus in bits [15:8], device in bits [7:3]) yields the same result.
- R2: A valid entry matches a masked identity r exactly when start <= r < start + length. The length is 17 bits wide, so length 0x10000 with start 0 covers every identity. Length 0 never matches.
- R3: On a hit, rsp_spec equals r - start + relocation base, taken modulo 2^16, and rsp_tgt equals the entry's target index.
- R4: When several valid entries match, the entry with the lowest table index supplies the result.
- R5: An entry whose valid flag is clear never matches. After reset every entry is invalid, so every lookup misses.
- R6: When no entry matches, rsp_hit is 0, rsp_miss is 1, and rsp_tgt and rsp_spec are both 0.
- R7: rsp_valid is 1 exactly one clock after a cycle with req_valid at 1. In a cycle after one without a request, rsp_valid, rsp_hit and rsp_miss are 0, and rsp_tgt and rsp_spec are 0. During reset all outputs are 0.
- R8: A write to an entry or to the mask affects lookups presented in later cycles. A lookup presented in the same cycle as the write uses the previous contents. Without a write, the table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_ent_we | input | 1 | Write one table entry this cycle |
| cfg_ent_idx | input | 3 | Entry index to write |
| cfg_vld | input | 1 | Valid flag for the written entry |
| cfg_rid_base | input | 16 | Range start |
| cfg_tgt | input | 2 | Target unit index |
| cfg_spec_base | input | 16 | Relocation base of the output identifier |
| cfg_len | input | 17 | Range length |
| cfg_mask_we | input | 1 | Write the mask this cycle |
| cfg_mask | input | 16 | New mask value |
| req_valid | input | 1 | Lookup request present |
| req_rid | input | 16 | Requester identity to look up |
| rsp_valid | output | 1 | Result present (one clock after the request) |
| rsp_hit | output | 1 | An entry matched |
| rsp_miss | output | 1 | No entry matched |
| rsp_tgt | output | 2 | Selected target unit index |
| rsp_spec | output | 16 | Translated sideband identifier |

## Verification
The bench builds the block with its default parameters: eight entries, 16-bit identities, 16-bit identifiers and a 17-bit length. With these values, one entry can span the full identity space. A relocation base near 0xFFFF can wrap the identifier. Eight entries also leave room for two overlapping ranges, which exercise the lowest-index rule.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  localparam int RID_W  = 16;
  localparam int LEN_W  = RID_W + 1;
  localparam int TGT_W  = 2;
  localparam int SPEC_W = 16;

  typedef struct packed {
    logic              vld;
    logic [RID_W-1:0]  rid_base;
    logic [TGT_W-1:0]  tgt;
    logic [SPEC_W-1:0] spec_base;
    logic [LEN_W-1:0]  len;
  } rng_ent_t;

  typedef struct packed {
    logic              vld;
    logic              hit;
    logic              miss;
    logic [TGT_W-1:0]  tgt;
    logic [SPEC_W-1:0] spec;
  } rng_rsp_t;
endpackage

// File: rtl/rmap_table.sv
module rmap_table
  import rmap_pkg::*;
#(
  parameter int NUM_ENT = 8,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  rng_ent_t                    wr_ent,
  input  logic                        mask_we,
  input  logic [RID_W-1:0]            mask_in,
  output rng_ent_t [NUM_ENT-1:0]      ents_o,
  output logic [RID_W-1:0]            mask_o
);
  logic [NUM_ENT-1:0] ent_ce;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_slot
    assign ent_ce[i] = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ents_o[i] <= '0;
      end else if (ent_ce[i]) begin
        ents_o[i] <= wr_ent;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '1;
    end else if (mask_we) begin
      mask_o <= mask_in;
    end
  end

  // R8: contents only move when the write port is used
  a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ents_o));
  a_r8_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_we |=> $stable(mask_o));
endmodule

// File: rtl/rmap_entry.sv
module rmap_entry
  import rmap_pkg::*;
(
  input  rng_ent_t          ent_i,
  input  logic [RID_W-1:0]  rid_i,
  output logic              match_o,
  output logic [TGT_W-1:0]  tgt_o,
  output logic [SPEC_W-1:0] spec_o
);
  localparam int CMP_W = LEN_W + 1;

  logic [CMP_W-1:0] lo_x;
  logic [CMP_W-1:0] hi_x;
  logic [CMP_W-1:0] r_x;
  logic [RID_W-1:0] off;

  assign lo_x = CMP_W'(ent_i.rid_base);
  assign hi_x = lo_x + CMP_W'(ent_i.len);
  assign r_x  = CMP_W'(rid_i);

  // half-open interval: start inclusive, end exclusive
  assign match_o = ent_i.vld && (r_x >= lo_x) && (r_x < hi_x);

  assign off    = rid_i - ent_i.rid_base;
  assign spec_o = SPEC_W'(off) + ent_i.spec_base;
  assign tgt_o  = ent_i.tgt;
endmodule

// File: rtl/rmap_pick.sv
module rmap_pick
  import rmap_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic [NUM_ENT-1:0]             match_i,
  input  logic [NUM_ENT-1:0][TGT_W-1:0]  tgt_i,
  input  logic [NUM_ENT-1:0][SPEC_W-1:0] spec_i,
  output logic [NUM_ENT-1:0]             oh_o,
  output logic                           any_o,
  output logic [TGT_W-1:0]               tgt_o,
  output logic [SPEC_W-1:0]              spec_o
);
  // isolate the lowest set bit: lowest index wins
  assign oh_o  = match_i & (~match_i + NUM_ENT'(1));
  assign any_o = |match_i;

  always_comb begin
    tgt_o  = '0;
    spec_o = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      tgt_o  = tgt_o  | (tgt_i[i]  & {TGT_W{oh_o[i]}});
      spec_o = spec_o | (spec_i[i] & {SPEC_W{oh_o[i]}});
    end
  end
endmodule

// File: rtl/rmap_unit.sv
module rmap_unit
  import rmap_pkg::*;
#(
  parameter int NUM_ENT = 8,
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ent_we,
  input  logic [IDX_W-1:0]  cfg_ent_idx,
  input  logic              cfg_vld,
  input  logic [RID_W-1:0]  cfg_rid_base,
  input  logic [TGT_W-1:0]  cfg_tgt,
  input  logic [SPEC_W-1:0] cfg_spec_base,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_mask_we,
  input  logic [RID_W-1:0]  cfg_mask,
  input  logic              req_valid,
  input  logic [RID_W-1:0]  req_rid,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [TGT_W-1:0]  rsp_tgt,
  output logic [SPEC_W-1:0] rsp_spec
);
  rng_ent_t                    wr_ent;
  rng_ent_t [NUM_ENT-1:0]      ents;
  logic [RID_W-1:0]            mask_q;
  logic [RID_W-1:0]            rid_m;
  logic [NUM_ENT-1:0]          match;
  logic [NUM_ENT-1:0][TGT_W-1:0]  e_tgt;
  logic [NUM_ENT-1:0][SPEC_W-1:0] e_spec;
  logic [NUM_ENT-1:0]          pick_oh;
  logic                        any_hit;
  logic [TGT_W-1:0]            sel_tgt;
  logic [SPEC_W-1:0]           sel_spec;
  rng_rsp_t                    rsp_d;
  rng_rsp_t                    rsp_q;

  assign wr_ent = '{vld: cfg_vld, rid_base: cfg_rid_base, tgt: cfg_tgt,
                    spec_base: cfg_spec_base, len: cfg_len};

  rmap_table #(.NUM_ENT(NUM_ENT)) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_ent_we),
    .wr_idx  (cfg_ent_idx),
    .wr_ent  (wr_ent),
    .mask_we (cfg_mask_we),
    .mask_in (cfg_mask),
    .ents_o  (ents),
    .mask_o  (mask_q)
  );

  assign rid_m = req_rid & mask_q;

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_cmp
    rmap_entry u_ent (
      .ent_i   (ents[i]),
      .rid_i   (rid_m),
      .match_o (match[i]),
      .tgt_o   (e_tgt[i]),
      .spec_o  (e_spec[i])
    );
  end

  rmap_pick #(.NUM_ENT(NUM_ENT)) u_pick (
    .match_i (match),
    .tgt_i   (e_tgt),
    .spec_i  (e_spec),
    .oh_o    (pick_oh),
    .any_o   (any_hit),
    .tgt_o   (sel_tgt),
    .spec_o  (sel_spec)
  );

  // next-state
  always_comb begin
    rsp_d = '0;
    if (req_valid) begin
      rsp_d.vld  = 1'b1;
      rsp_d.hit  = any_hit;
      rsp_d.miss = !any_hit;
      rsp_d.tgt  = sel_tgt;
      rsp_d.spec = sel_spec;
    end
  end

  // register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= '0;
    end else begin
      rsp_q <= rsp_d;
    end
  end

  assign rsp_valid = rsp_q.vld;
  assign rsp_hit   = rsp_q.hit;
  assign rsp_miss  = rsp_q.miss;
  assign rsp_tgt   = rsp_q.tgt;
  assign rsp_spec  = rsp_q.spec;

  a_r4_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick_oh) && ((pick_oh == '0) == (match == '0)));
  a_r7_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r7_quiet_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && rsp_tgt == '0 && rsp_spec == '0));
  a_r6_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (!rsp_hit && rsp_tgt == '0 && rsp_spec == '0));
  a_r7_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss));
endmodule

// File: tb/tb_rmap_unit.sv
`timescale 1ns/1ps
module tb_rmap_unit;
  logic        clk;
  logic        rst_n;
  logic        cfg_ent_we;
  logic [2:0]  cfg_ent_idx;
  logic        cfg_vld;
  logic [15:0] cfg_rid_base;
  logic [1:0]  cfg_tgt;
  logic [15:0] cfg_spec_base;
  logic [16:0] cfg_len;
  logic        cfg_mask_we;
  logic [15:0] cfg_mask;
  logic        req_valid;
  logic [15:0] req_rid;
  logic        rsp_valid;
  logic        rsp_hit;
  logic        rsp_miss;
  logic [1:0]  rsp_tgt;
  logic [15:0] rsp_spec;

  rmap_unit dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_ent_we(cfg_ent_we), .cfg_ent_idx(cfg_ent_idx), .cfg_vld(cfg_vld),
    .cfg_rid_base(cfg_rid_base), .cfg_tgt(cfg_tgt), .cfg_spec_base(cfg_spec_base),
    .cfg_len(cfg_len), .cfg_mask_we(cfg_mask_we), .cfg_mask(cfg_mask),
    .req_valid(req_valid), .req_rid(req_rid),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_tgt(rsp_tgt), .rsp_spec(rsp_spec)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_errors = 0;
  string cur_req  = "R7";
  bit    started  = 1'b0;
  bit    done     = 1'b0;

  // behavioural model of the table
  bit m_vld [8];
  int m_base[8];
  int m_tgt [8];
  int m_sb  [8];
  int m_len [8];
  int m_mask;
  int e_v, e_hit, e_miss, e_tgt, e_spec;

  always @(posedge clk) begin
    started = 1'b1;
    if (!rst_n) begin
      e_v = 0; e_hit = 0; e_miss = 0; e_tgt = 0; e_spec = 0;
      for (int i = 0; i < 8; i++) m_vld[i] = 1'b0;
      m_mask = 'hFFFF;
    end else begin
      e_v = int'(req_valid); e_hit = 0; e_miss = 0; e_tgt = 0; e_spec = 0;
      if (req_valid) begin
        int r;
        bit found;
        r = int'(req_rid) & m_mask;
        found = 1'b0;
        for (int i = 0; i < 8; i++) begin
          if (!found && m_vld[i] && r >= m_base[i] && r < m_base[i] + m_len[i]) begin
            found  = 1'b1;
            e_tgt  = m_tgt[i];
            e_spec = (r - m_base[i] + m_sb[i]) & 'hFFFF;
          end
        end
        e_hit  = int'(found);
        e_miss = int'(!found);
      end
      if (cfg_ent_we) begin
        m_vld [cfg_ent_idx] = cfg_vld;
        m_base[cfg_ent_idx] = int'(cfg_rid_base);
        m_tgt [cfg_ent_idx] = int'(cfg_tgt);
        m_sb  [cfg_ent_idx] = int'(cfg_spec_base);
        m_len [cfg_ent_idx] = int'(cfg_len);
      end
      if (cfg_mask_we) m_mask = int'(cfg_mask);
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      n_checks++;
      if (int'(rsp_valid) != e_v || int'(rsp_hit) != e_hit || int'(rsp_miss) != e_miss ||
          int'(rsp_tgt) != e_tgt || int'(rsp_spec) != e_spec) begin
        n_errors++;
        $display("FAIL %s: got v=%0d h=%0d m=%0d tgt=%0d spec=%h exp v=%0d h=%0d m=%0d tgt=%0d spec=%h",
                 cur_req, rsp_valid, rsp_hit, rsp_miss, rsp_tgt, rsp_spec,
                 e_v, e_hit, e_miss, e_tgt, e_spec[15:0]);
      end
    end
  end

  task automatic quiet();
    cfg_ent_we = 1'b0; cfg_mask_we = 1'b0; req_valid = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk); quiet();
  endtask

  task automatic put(input int idx, input bit v, input int base, input int tgt,
                     input int sb, input int len);
    @(negedge clk); quiet();
    cfg_ent_we = 1'b1; cfg_ent_idx = 3'(idx); cfg_vld = v;
    cfg_rid_base = 16'(base); cfg_tgt = 2'(tgt); cfg_spec_base = 16'(sb); cfg_len = 17'(len);
  endtask

  task automatic set_mask(input int m);
    @(negedge clk); quiet();
    cfg_mask_we = 1'b1; cfg_mask = 16'(m);
  endtask

  task automatic look(input int rid);
    @(negedge clk); quiet();
    req_valid = 1'b1; req_rid = 16'(rid);
  endtask

  initial begin
    rst_n = 1'b0;
    quiet();
    cfg_ent_idx = '0; cfg_vld = 1'b0; cfg_rid_base = '0; cfg_tgt = '0;
    cfg_spec_base = '0; cfg_len = '0; cfg_mask = '0; req_rid = '0;
    repeat (3) @(negedge clk);
    cur_req = "R7";
    rst_n = 1'b1;
    idle(); idle();

    cur_req = "R5";
    look('h1234); look('h0000); look('hFFFF); idle();

    cur_req = "R2";
    put(0, 1, 0, 1, 0, 'h10000);
    look('h0000); look('hFFFF); look('h1234); idle();

    cur_req = "R1";
    set_mask('hFFF8);
    look('h1235); look('h1237); look('h1230); look('hABCF); idle();
    set_mask('hFFFF);

    cur_req = "R3";
    put(0, 0, 0, 1, 0, 'h10000);
    put(1, 1, 'h0000, 2, 'h8000, 'h8000);
    put(2, 1, 'h8000, 3, 'h0000, 'h8000);
    look('h7FFF); look('h8000); look('h0000); look('hFFFF); look('h1234); idle();

    cur_req = "R5";
    put(1, 0, 0, 2, 'h8000, 'h8000);
    put(2, 0, 'h8000, 3, 0, 'h8000);
    look('h7FFF); look('h8000); idle();

    cur_req = "R2";
    put(3, 1, 'h0100, 1, 'h0040, 'h10);
    look('h00FF); look('h0100); look('h010F); look('h0110); idle();
    put(5, 1, 'h0200, 2, 'h0000, 0);
    look('h0200); look('h01FF); idle();

    cur_req = "R4";
    put(4, 1, 'h0100, 2, 'h1000, 'h100);
    look('h0105); look('h0150); look('h010F); look('h0110); idle();

    cur_req = "R3";
    put(6, 1, 'h3000, 3, 'hFFF0, 'h100);
    look('h3020); look('h300F); look('h3010); idle();

    cur_req = "R8";
    @(negedge clk); quiet();
    cfg_ent_we = 1'b1; cfg_ent_idx = 3'd7; cfg_vld = 1'b1; cfg_rid_base = 16'h5000;
    cfg_tgt = 2'd1; cfg_spec_base = 16'h0777; cfg_len = 17'h10;
    req_valid = 1'b1; req_rid = 16'h5003;
    look('h5003);
    @(negedge clk); quiet();
    cfg_mask_we = 1'b1; cfg_mask = 16'h0FFF; req_valid = 1'b1; req_rid = 16'hF105;
    look('hF105); idle();
    set_mask('hFFFF);

    cur_req = "R7";
    idle(); idle(); look('h0100); idle(); idle();

    cur_req = "R4";
    for (int k = 0; k < 400; k++) begin
      if (k % 25 == 0)
        put(k % 8, ($urandom % 4) != 0, $urandom % 'h10000, $urandom % 4,
            $urandom % 'h10000, $urandom % 'h4000);
      else if (k % 7 == 0)
        idle();
      else
        look($urandom % 'h10000);
    end
    idle(); idle();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: got no end of run, exp end of run");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule